// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test and debug entry point of a chip. A host drives a test clock, a mode-select line and a serial data input. From these the block steps a sixteen-state controller through select, capture, shift, pause and update phases, once for the instruction path and once for the data path. A shifted-in opcode is held in an instruction latch. The latch selects which data register sits between the serial input and the serial output: a one-bit pass-through, a 32-bit identification code, a 32-bit user code, or an external boundary-scan chain.

The boundary chain itself lives outside this block. The block supplies that chain with gated capture, shift and update strobes and a test-mode level. It also supplies a pin float request. Together these let the chain drive or observe pins (external test), sample them transparently (sample/preload), freeze them at preloaded values (clamp) or float them (high-impedance). The last two keep the short pass-through register in the serial path. The serial output is launched on the falling clock edge and carries a separate enable. That enable is high only while bits are being shifted.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller steps through the sixteen states on each rising edge of `tck` according to `tms`. Five consecutive rising edges with `tms` high reach the reset state from any state, and four edges from the pause-DR state do not.
- R2: While `trst_n` is low, the block sits asynchronously in the reset state: `tap_reset` high, `ir_value` holding the IDCODE opcode 4'b0010, and `tdo_oe` low.
- R3: In Capture-IR the instruction shift register loads 4'b0001, which shifts out least significant bit first as 1,0,0,0.
- R4: `ir_value` changes only on the rising edge that leaves Update-IR, or in the reset state. During Shift-IR and Exit1-IR it holds its previous value.
- R5: `tdo` changes on falling edges of `tck`. `tdo_oe` is high only in Shift-IR or Shift-DR and low in Run-Test/Idle.
- R6: BYPASS (4'b1111) and every undefined opcode place a one-bit register, which captures 0, between `tdi` and `tdo`.
- R7: IDCODE (4'b0010) shifts out the 32-bit IDCODE value, LSB first. USERCODE (4'b0011) shifts out the 32-bit USERCODE value.
- R8: EXTEST (4'b0000) selects the boundary chain with `bsr_test_mode`=1. SAMPLE (4'b0001) selects it with `bsr_test_mode`=0. In both, `tdo` follows `bsr_so` during Shift-DR and `pins_hiz`=0.
- R9: CLAMP (4'b0100) selects the one-bit register with `bsr_test_mode`=1 and `pins_hiz`=0. HIGHZ (4'b0101) selects it with `bsr_test_mode`=1 and `pins_hiz`=1.
- R10: `bsr_capture`, `bsr_shift` and `bsr_update` are high only in Capture-DR, Shift-DR and Update-DR respectively, and only when the boundary chain is selected. At most one of them is high at a time.
- R11: After the reset state is entered through `tms`, the instruction latch holds IDCODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_test_mode | output | 1 | Boundary cells drive pins from update latches |
| pins_hiz | output | 1 | Request to float all pins |
| tap_reset | output | 1 | Controller is in the reset state |
| ir_value | output | 4 | Current instruction latch contents |

## Verification
The bench targets the off-by-one places in this block. It reads the first bit out of the one-bit register, where a design that skips the capture of 0 returns stale data. It checks that the latch is unchanged in Exit1-IR, where a design that copies the shift register every cycle exposes half-shifted opcodes. It counts TMS-high edges from pause-DR, where four edges must not reset and five must. It drops `trst_n` in the middle of a data shift, which must clear the output enable and the latch at once rather than on the next clock. Every opcode, including two undefined ones, is checked for its register length and its mode pins, so a swapped EXTEST and SAMPLE mode or a CLAMP that floats the pins would show at the ports.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

   typedef enum logic [3:0] {
      ST_EX2_DR = 4'h0,
      ST_EX1_DR = 4'h1,
      ST_SHF_DR = 4'h2,
      ST_PAU_DR = 4'h3,
      ST_SEL_IR = 4'h4,
      ST_UPD_DR = 4'h5,
      ST_CAP_DR = 4'h6,
      ST_SEL_DR = 4'h7,
      ST_EX2_IR = 4'h8,
      ST_EX1_IR = 4'h9,
      ST_SHF_IR = 4'hA,
      ST_PAU_IR = 4'hB,
      ST_IDLE   = 4'hC,
      ST_UPD_IR = 4'hD,
      ST_CAP_IR = 4'hE,
      ST_RESET  = 4'hF
   } tap_state_e;

   typedef enum logic [1:0] {
      DR_PASS     = 2'd0,
      DR_IDENT    = 2'd1,
      DR_USER     = 2'd2,
      DR_BOUNDARY = 2'd3
   } dr_sel_e;

   typedef struct packed {
      dr_sel_e dr_sel;
      logic    test_mode;
      logic    float_pins;
   } ir_decode_t;

   // Successor of a controller state for a given mode-select level.
   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      tap_state_e n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
         ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
         ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
   import jtag_tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e state_d;

   always_comb begin
      state_d = tap_next(state, tms);
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_RESET;
      end else begin
         state <= state_d;
      end
   end

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
   import jtag_tap_pkg::*;
#(
   parameter int unsigned        IR_W         = 4,
   parameter logic [IR_W-1:0]    OP_EXTEST    = 4'b0000,
   parameter logic [IR_W-1:0]    OP_SAMPLE    = 4'b0001,
   parameter logic [IR_W-1:0]    OP_IDCODE    = 4'b0010,
   parameter logic [IR_W-1:0]    OP_USERCODE  = 4'b0011,
   parameter logic [IR_W-1:0]    OP_CLAMP     = 4'b0100,
   parameter logic [IR_W-1:0]    OP_HIGHZ     = 4'b0101,
   parameter bit                 USE_USERCODE = 1'b1
)(
   input  logic            tck,
   input  logic            rst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic            ir_lsb,
   output logic [1:0]      ir_low,
   output logic [IR_W-1:0] ir_q,
   output ir_decode_t      dec
);

   localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(2'b01);

   logic [IR_W-1:0] ir_sr;
   logic            user_hit;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_sr <= CAPTURE_PAT;
      end else if (state == ST_CAP_IR) begin
         ir_sr <= CAPTURE_PAT;
      end else if (state == ST_SHF_IR) begin
         ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_q <= OP_IDCODE;
      end else if (state == ST_RESET) begin
         ir_q <= OP_IDCODE;
      end else if (state == ST_UPD_IR) begin
         ir_q <= ir_sr;
      end
   end

   generate
      if (USE_USERCODE) begin : g_user
         assign user_hit = (ir_q == OP_USERCODE);
      end else begin : g_nouser
         assign user_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      dec.dr_sel     = DR_PASS;
      dec.test_mode  = 1'b0;
      dec.float_pins = 1'b0;
      if (ir_q == OP_EXTEST) begin
         dec.dr_sel    = DR_BOUNDARY;
         dec.test_mode = 1'b1;
      end else if (ir_q == OP_SAMPLE) begin
         dec.dr_sel = DR_BOUNDARY;
      end else if (ir_q == OP_IDCODE) begin
         dec.dr_sel = DR_IDENT;
      end else if (user_hit) begin
         dec.dr_sel = DR_USER;
      end else if (ir_q == OP_CLAMP) begin
         dec.test_mode = 1'b1;
      end else if (ir_q == OP_HIGHZ) begin
         dec.test_mode  = 1'b1;
         dec.float_pins = 1'b1;
      end
   end

   assign ir_lsb = ir_sr[0];
   assign ir_low = ir_sr[1:0];

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
   import jtag_tap_pkg::*;
#(
   parameter int unsigned      ID_W     = 32,
   parameter logic [ID_W-1:0]  IDCODE   = 32'h1234_5679,
   parameter logic [ID_W-1:0]  USERCODE = 32'hCAFE_0001
)(
   input  logic       tck,
   input  logic       rst_n,
   input  tap_state_e state,
   input  dr_sel_e    dr_sel,
   input  logic       tdi,
   input  logic       bsr_so,
   output logic       dr_lsb
);

   logic            pass_q;
   logic [ID_W-1:0] id_sr;
   logic            id_sel;

   assign id_sel = (dr_sel == DR_IDENT) || (dr_sel == DR_USER);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         pass_q <= 1'b0;
      end else if (dr_sel == DR_PASS) begin
         if (state == ST_CAP_DR) begin
            pass_q <= 1'b0;
         end else if (state == ST_SHF_DR) begin
            pass_q <= tdi;
         end
      end
   end

   // One shift register serves both identification codes.
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         id_sr <= IDCODE;
      end else if (id_sel) begin
         if (state == ST_CAP_DR) begin
            id_sr <= (dr_sel == DR_USER) ? USERCODE : IDCODE;
         end else if (state == ST_SHF_DR) begin
            id_sr <= {tdi, id_sr[ID_W-1:1]};
         end
      end
   end

   always_comb begin
      case (dr_sel)
         DR_PASS:     dr_lsb = pass_q;
         DR_IDENT:    dr_lsb = id_sr[0];
         DR_USER:     dr_lsb = id_sr[0];
         DR_BOUNDARY: dr_lsb = bsr_so;
         default:     dr_lsb = pass_q;
      endcase
   end

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
   import jtag_tap_pkg::*;
#(
   parameter int unsigned      IR_W         = 4,
   parameter int unsigned      ID_W         = 32,
   parameter logic [ID_W-1:0]  IDCODE       = 32'h1234_5679,
   parameter logic [ID_W-1:0]  USERCODE     = 32'hCAFE_0001,
   parameter bit               HAS_TRST     = 1'b1,
   parameter bit               USE_USERCODE = 1'b1,
   parameter logic [IR_W-1:0]  OP_EXTEST    = 4'b0000,
   parameter logic [IR_W-1:0]  OP_SAMPLE    = 4'b0001,
   parameter logic [IR_W-1:0]  OP_IDCODE    = 4'b0010,
   parameter logic [IR_W-1:0]  OP_USERCODE  = 4'b0011,
   parameter logic [IR_W-1:0]  OP_CLAMP     = 4'b0100,
   parameter logic [IR_W-1:0]  OP_HIGHZ     = 4'b0101,
   parameter logic [IR_W-1:0]  OP_BYPASS    = 4'b1111
)(
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tms,
   input  logic            tdi,
   input  logic            bsr_so,
   output logic            tdo,
   output logic            tdo_oe,
   output logic            bsr_capture,
   output logic            bsr_shift,
   output logic            bsr_update,
   output logic            bsr_test_mode,
   output logic            pins_hiz,
   output logic            tap_reset,
   output logic [IR_W-1:0] ir_value
);

   // Elaboration-time parameter checks
   generate
      if (IR_W < 2) begin : g_bad_irw
         $error("IR_W must be at least 2");
      end
      if (ID_W < 2) begin : g_bad_idw
         $error("ID_W must be at least 2");
      end
      if (IDCODE[0] != 1'b1) begin : g_bad_id
         $error("IDCODE bit 0 must be 1");
      end
      if (OP_BYPASS != {IR_W{1'b1}}) begin : g_bad_byp
         $error("OP_BYPASS must be all ones");
      end
   endgenerate

   logic       rst_n;
   tap_state_e state;
   ir_decode_t dec;
   logic       ir_lsb;
   logic [1:0] ir_low;
   logic       dr_lsb;
   logic       bsr_sel;
   logic       in_shift;

   generate
      if (HAS_TRST) begin : g_trst
         assign rst_n = trst_n;
      end else begin : g_no_trst
         assign rst_n = 1'b1;
      end
   endgenerate

   jtag_tap_fsm i_fsm (
      .tck   (tck),
      .rst_n (rst_n),
      .tms   (tms),
      .state (state)
   );

   jtag_tap_ir #(
      .IR_W         (IR_W),
      .OP_EXTEST    (OP_EXTEST),
      .OP_SAMPLE    (OP_SAMPLE),
      .OP_IDCODE    (OP_IDCODE),
      .OP_USERCODE  (OP_USERCODE),
      .OP_CLAMP     (OP_CLAMP),
      .OP_HIGHZ     (OP_HIGHZ),
      .USE_USERCODE (USE_USERCODE)
   ) i_ir (
      .tck    (tck),
      .rst_n  (rst_n),
      .state  (state),
      .tdi    (tdi),
      .ir_lsb (ir_lsb),
      .ir_low (ir_low),
      .ir_q   (ir_value),
      .dec    (dec)
   );

   jtag_tap_dr #(
      .ID_W     (ID_W),
      .IDCODE   (IDCODE),
      .USERCODE (USERCODE)
   ) i_dr (
      .tck    (tck),
      .rst_n  (rst_n),
      .state  (state),
      .dr_sel (dec.dr_sel),
      .tdi    (tdi),
      .bsr_so (bsr_so),
      .dr_lsb (dr_lsb)
   );

   assign in_shift = (state == ST_SHF_DR) || (state == ST_SHF_IR);

   // Output stage launched on the falling edge
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= (state == ST_SHF_IR) ? ir_lsb : dr_lsb;
         tdo_oe <= in_shift;
      end
   end

   assign bsr_sel       = (dec.dr_sel == DR_BOUNDARY);
   assign bsr_capture   = bsr_sel && (state == ST_CAP_DR);
   assign bsr_shift     = bsr_sel && (state == ST_SHF_DR);
   assign bsr_update    = bsr_sel && (state == ST_UPD_DR);
   assign bsr_test_mode = dec.test_mode;
   assign pins_hiz      = dec.float_pins;
   assign tap_reset     = (state == ST_RESET);

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
   import jtag_tap_pkg::*;
#(
   parameter int unsigned     IR_W      = 4,
   parameter logic [IR_W-1:0] OP_IDCODE = 4'b0010
)(
   input logic            tck,
   input logic            trst_n,
   input logic            tms,
   input tap_state_e      state,
   input logic [IR_W-1:0] ir_q,
   input logic [1:0]      ir_low,
   input logic            tdo_oe,
   input logic            bsr_capture,
   input logic            bsr_shift,
   input logic            bsr_update,
   input logic            bsr_test_mode,
   input logic            pins_hiz
);

   logic [2:0] ones_cnt;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ones_cnt <= 3'd0;
      end else if (!tms) begin
         ones_cnt <= 3'd0;
      end else if (ones_cnt != 3'd5) begin
         ones_cnt <= ones_cnt + 3'd1;
      end
   end

   AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
      ones_cnt == 3'd5 |-> state == ST_RESET); // R1

   AST_IR_UPDATE_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
      !$stable(ir_q) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET)); // R4

   AST_RESET_LOADS_ID: assert property (@(posedge tck) disable iff (!trst_n)
      state == ST_RESET |=> ir_q == OP_IDCODE); // R11

   AST_CAPIR_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
      state == ST_CAP_IR |=> ir_low == 2'b01); // R3

   AST_OE_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe |-> (state == ST_SHF_DR || state == ST_SHF_IR)); // R5

   AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({bsr_capture, bsr_shift, bsr_update})); // R10

   AST_HIZ_IN_TEST: assert property (@(posedge tck) disable iff (!trst_n)
      pins_hiz |-> bsr_test_mode); // R9

endmodule

bind jtag_tap_ctrl jtag_tap_chk #(
   .IR_W      (IR_W),
   .OP_IDCODE (OP_IDCODE)
) i_chk (
   .tck           (tck),
   .trst_n        (trst_n),
   .tms           (tms),
   .state         (state),
   .ir_q          (ir_value),
   .ir_low        (ir_low),
   .tdo_oe        (tdo_oe),
   .bsr_capture   (bsr_capture),
   .bsr_shift     (bsr_shift),
   .bsr_update    (bsr_update),
   .bsr_test_mode (bsr_test_mode),
   .pins_hiz      (pins_hiz)
);

// File: tb/test_jtag_tap_ctrl.sv
module test_jtag_tap_ctrl;

   localparam logic [31:0] ID_VAL   = 32'h1234_5679;
   localparam logic [31:0] USER_VAL = 32'hCAFE_0001;
   localparam logic [3:0]  OPC_ID   = 4'b0010;
   localparam logic [3:0]  OPC_BYP  = 4'b1111;
   localparam logic [31:0] DIN      = 32'hA5C3_0F96;

   // kind: 0 one-bit pass, 1 ident, 2 user, 3 boundary
   typedef struct packed {
      logic [3:0] op;
      logic [1:0] kind;
      logic       mode;
      logic       hiz;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{4'b0000, 2'd3, 1'b1, 1'b0},   // R8 external test
      '{4'b0001, 2'd3, 1'b0, 1'b0},   // R8 sample/preload
      '{4'b0010, 2'd1, 1'b0, 1'b0},   // R7 ident
      '{4'b0011, 2'd2, 1'b0, 1'b0},   // R7 user code
      '{4'b0100, 2'd0, 1'b1, 1'b0},   // R9 clamp
      '{4'b0101, 2'd0, 1'b1, 1'b1},   // R9 float
      '{4'b1111, 2'd0, 1'b0, 1'b0},   // R6 bypass
      '{4'b1010, 2'd0, 1'b0, 1'b0},   // R6 undefined
      '{4'b0110, 2'd0, 1'b0, 1'b0}    // R6 undefined
   };

   logic       tck = 1'b0;
   logic       trst_n = 1'b1;
   logic       tms = 1'b1;
   logic       tdi = 1'b0;
   logic       bsr_so = 1'b1;
   logic       tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update;
   logic       bsr_test_mode, pins_hiz, tap_reset;
   logic [3:0] ir_value;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 tck = ~tck;

   jtag_tap_ctrl i_jtag_tap_ctrl (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
      .tdo(tdo), .tdo_oe(tdo_oe), .bsr_capture(bsr_capture),
      .bsr_shift(bsr_shift), .bsr_update(bsr_update),
      .bsr_test_mode(bsr_test_mode), .pins_hiz(pins_hiz),
      .tap_reset(tap_reset), .ir_value(ir_value)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // One TCK cycle: sample tdo for the coming edge, drive inputs, settle after the edge.
   task automatic step(input logic m, input logic d, output logic so, output logic oe);
      @(negedge tck);
      #1;
      so  = tdo;
      oe  = tdo_oe;
      tms = m;
      tdi = d;
      @(posedge tck);
      #2;
   endtask

   task automatic go_idle();
      logic so, oe;
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, so, oe);
      step(1'b0, 1'b0, so, oe);
   endtask

   task automatic load_ir(input logic [3:0] op, input logic [3:0] prev);
      logic so, oe;
      logic [3:0] cap;
      logic oe_all;
      oe_all = 1'b1;
      step(1'b1, 1'b0, so, oe);
      step(1'b1, 1'b0, so, oe);
      step(1'b0, 1'b0, so, oe);
      step(1'b0, 1'b0, so, oe);
      for (int i = 0; i < 4; i++) begin
         step(i == 3, op[i], so, oe);
         cap[i] = so;
         oe_all = oe_all & oe;
      end
      chk("R3 capture-IR pattern", cap, 4'b0001);
      chk("R5 oe during shift-IR", oe_all, 1'b1);
      chk("R4 latch held in exit1-IR", ir_value, prev);
      step(1'b1, 1'b0, so, oe);
      step(1'b0, 1'b0, so, oe);
      chk("R4 latch after update-IR", ir_value, op);
   endtask

   task automatic scan_dr(input logic exp_bsr, output logic [31:0] dout);
      logic so, oe;
      logic oe_all;
      oe_all = 1'b1;
      step(1'b1, 1'b0, so, oe);
      step(1'b0, 1'b0, so, oe);
      chk("R10 capture strobe", bsr_capture, exp_bsr);
      step(1'b0, 1'b0, so, oe);
      chk("R10 shift strobe", bsr_shift, exp_bsr);
      for (int i = 0; i < 32; i++) begin
         step(i == 31, DIN[i], so, oe);
         dout[i] = so;
         oe_all  = oe_all & oe;
      end
      chk("R5 oe during shift-DR", oe_all, 1'b1);
      step(1'b1, 1'b0, so, oe);
      chk("R10 update strobe", bsr_update, exp_bsr);
      step(1'b0, 1'b0, so, oe);
      chk("R5 oe low in idle", tdo_oe, 1'b0);
      chk("R10 strobes low in idle", {bsr_capture, bsr_shift, bsr_update}, 3'b000);
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] dout;
      logic [31:0] exp;
      logic [3:0]  prev;
      logic so, oe;

      // R2: reset state
      #1 trst_n = 1'b0;
      #2;
      chk("R2 tap_reset", tap_reset, 1'b1);
      chk("R2 ir_value", ir_value, OPC_ID);
      chk("R2 tdo_oe", tdo_oe, 1'b0);
      @(posedge tck);
      @(posedge tck);
      #1 trst_n = 1'b1;
      go_idle();
      chk("R1 idle after tms low", tap_reset, 1'b0);

      // R7/R11: default instruction reads the ident code
      scan_dr(1'b0, dout);
      chk("R7 default ident readout", dout, ID_VAL);

      // Table walk over every opcode class
      prev = OPC_ID;
      foreach (VECS[k]) begin
         load_ir(VECS[k].op, prev);
         prev = VECS[k].op;
         chk("R8 R9 test mode", bsr_test_mode, VECS[k].mode);
         chk("R9 pin float", pins_hiz, VECS[k].hiz);
         scan_dr(VECS[k].kind == 2'd3, dout);
         case (VECS[k].kind)
            2'd0:    exp = {DIN[30:0], 1'b0};
            2'd1:    exp = ID_VAL;
            2'd2:    exp = USER_VAL;
            default: exp = 32'hFFFF_FFFF;
         endcase
         chk("R6 R7 R8 data path", dout, exp);
      end

      // R1/R11: four ones from pause-DR do not reset, five do
      step(1'b1, 1'b0, so, oe);
      step(1'b0, 1'b0, so, oe);
      step(1'b1, 1'b0, so, oe);
      step(1'b0, 1'b0, so, oe);
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, so, oe);
      chk("R1 four ones no reset", tap_reset, 1'b0);
      chk("R11 latch kept before reset", ir_value, 4'b0110);
      step(1'b1, 1'b0, so, oe);
      chk("R1 fifth one resets", tap_reset, 1'b1);
      step(1'b1, 1'b0, so, oe);
      chk("R11 latch ident after reset", ir_value, OPC_ID);

      // R1: five ones from the middle of an instruction shift
      step(1'b0, 1'b0, so, oe);
      load_ir(OPC_BYP, OPC_ID);
      step(1'b1, 1'b0, so, oe);
      step(1'b1, 1'b0, so, oe);
      step(1'b0, 1'b0, so, oe);
      step(1'b0, 1'b1, so, oe);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b1, so, oe);
      chk("R1 reset from shift-IR", tap_reset, 1'b1);
      step(1'b0, 1'b0, so, oe);

      // R2: asynchronous reset in the middle of a data shift
      load_ir(OPC_BYP, OPC_ID);
      step(1'b1, 1'b0, so, oe);
      step(1'b0, 1'b0, so, oe);
      step(1'b0, 1'b0, so, oe);
      step(1'b0, 1'b1, so, oe);
      chk("R5 oe high in shift-DR", tdo_oe, 1'b1);
      #5 trst_n = 1'b0;
      #1;
      chk("R2 async tap_reset", tap_reset, 1'b1);
      chk("R2 async ir_value", ir_value, OPC_ID);
      chk("R2 async tdo_oe", tdo_oe, 1'b0);
      @(posedge tck);
      #1 trst_n = 1'b1;
      step(1'b0, 1'b0, so, oe);
      scan_dr(1'b0, dout);
      chk("R7 ident after async reset", dout, ID_VAL);

      finish_run();
   end

endmodule